// File: doc/BRIEF.md
# Timer Power-Mode Clock-Enable Controller

This block decides, every clock cycle, whether a general-purpose timer core and its companion pulse accumulator may advance. It combines software enable bits held in a small control register file with the CPU's current power state (run, wait, stop or background debug). From these it produces registered tick enables for the timer core and for the accumulator. It also produces a flag that says whether the control registers may be accessed, and a select that hands the pin shared with timer channel 7 over to the accumulator input.

The CPU status inputs may be asserted together. The block resolves them with stop first, then wait, then debug. When none of them is asserted the CPU is in run mode. A simple single-cycle bus reads and writes three control registers. While the register access flag is low, an access is refused. A refused read returns zero, a refused write changes nothing, and one cycle later a one-cycle error pulse appears.

Top module: `tmr_pwr_ctl`

## Requirements
- R1: After reset all control bits are zero, both tick enables, the pin select and the error pulse are low, and the access flag is high.
- R2: In run mode the timer tick enable equals the timer enable bit (SYS bit 0) and the accumulator tick enable equals the accumulator enable bit (ACC bit 0); registers stay accessible whatever those bits are.
- R3: With the debug-freeze bit (SYS bit 1) clear, debug mode gives the same enables as run mode.
- R4: With the debug-freeze bit set, debug mode forces the timer tick enable low, and also the accumulator tick enable unless event mode is selected.
- R5: With the event-mode bit (ACC bit 2) set, the accumulator tick enable in a frozen debug mode equals its enable bit.
- R6: With the wait-freeze bit (SYS bit 2) set, wait mode forces both tick enables and the access flag low.
- R7: With the wait-freeze bit clear, wait mode gives the run-mode enables and keeps access allowed.
- R8: Entering and leaving a wait freeze leaves the stored enable bits unchanged, so the enables come back after the freeze ends.
- R9: Stop mode forces both tick enables and the access flag low, whatever the control bits are.
- R10: When several status inputs are asserted, stop wins over wait and wait wins over debug.
- R11: The pin select is high only when the pin enable (ACC bit 1) is set and the channel-7 output mode, output level and compare-mask bits (CH7 bits 0, 1 and 2) are all clear.
- R12: A refused access returns zero read data, does not change any register, and raises the error output for exactly the cycle after the access.
- R13: All enables, the access flag and the pin select change on the first clock edge after their inputs change.
- R14: Registers sit at address 0 (SYS), 1 (ACC) and 2 (CH7) with three bits each, and other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| cpu_stop_i | input | 1 | CPU is in stop mode |
| cpu_wait_i | input | 1 | CPU is in wait mode |
| cpu_dbg_i | input | 1 | CPU is in background debug |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| bus_err_o | output | 1 | One-cycle pulse after a refused access |
| tmr_tick_en_o | output | 1 | Timer core may advance |
| acc_tick_en_o | output | 1 | Pulse accumulator may advance |
| reg_access_ok_o | output | 1 | Register access is allowed |
| ch7_to_acc_o | output | 1 | Shared pin is routed to the accumulator |

## Verification
A wrong decoded mode or a stale enable register shows up at a tick enable or at the access flag one cycle after the stimulus. For that reason every combination of status inputs and control bits is held for two cycles and compared with a truth table. A register that a refused write corrupted does not show until the freeze ends. It is then seen when the register is read back, and the enables also fail to return. A mistimed error pulse is caught by sampling it in the cycle after the access and again in the cycle after that.

// File: rtl/tmr_pwr_pkg.sv
package tmr_pwr_pkg;

   typedef enum logic [1:0] {
      MODE_RUN  = 2'd0,
      MODE_DBG  = 2'd1,
      MODE_WAIT = 2'd2,
      MODE_STOP = 2'd3
   } pwr_mode_e;

   localparam int unsigned FIELD_W = 3;
   localparam int unsigned NREG    = 3;
   localparam int unsigned FLAT_W  = FIELD_W * NREG;

   localparam int unsigned REG_SYS = 0;
   localparam int unsigned REG_ACC = 1;
   localparam int unsigned REG_CH7 = 2;

   typedef struct packed {
      logic ch7_mask;
      logic ch7_lvl;
      logic ch7_mode;
      logic acc_evt;
      logic acc_pin_en;
      logic acc_en;
      logic wait_frz;
      logic dbg_frz;
      logic tmr_en;
   } ctl_t;

endpackage

// File: rtl/tmr_pwr_mode_dec.sv
module tmr_pwr_mode_dec
   import tmr_pwr_pkg::*;
(
   input  logic      stop_i,
   input  logic      wait_i,
   input  logic      dbg_i,
   output pwr_mode_e mode_o
);

   always_comb begin
      if (stop_i)      mode_o = MODE_STOP;
      else if (wait_i) mode_o = MODE_WAIT;
      else if (dbg_i)  mode_o = MODE_DBG;
      else             mode_o = MODE_RUN;
   end

endmodule

// File: rtl/tmr_pwr_regs.sv
module tmr_pwr_regs
   import tmr_pwr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              acc_ok_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              err_o,
   output ctl_t              ctl_o
);

   localparam int unsigned PAD_W = DATA_W - FIELD_W;

   initial begin
      assert (DATA_W >= FIELD_W) else $error("DATA_W narrower than a register field");
      assert (ADDR_W >= 2)       else $error("ADDR_W too small for the register map");
   end

   logic [FLAT_W-1:0]  flat_q;
   logic [FIELD_W-1:0] rd_field;
   logic               wr_ok;
   logic               rd_ok;

   assign wr_ok = sel_i & wr_i & acc_ok_i;
   assign rd_ok = sel_i & ~wr_i & acc_ok_i;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [FIELD_W-1:0] field_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            field_q <= '0;
         else if (wr_ok && (addr_i == ADDR_W'(g)))
            field_q <= wdata_i[FIELD_W-1:0];
      end
      assign flat_q[g*FIELD_W +: FIELD_W] = field_q;
   end

   always_comb begin
      rd_field = '0;
      for (int i = 0; i < NREG; i++) begin
         if (rd_ok && (addr_i == ADDR_W'(i)))
            rd_field = flat_q[i*FIELD_W +: FIELD_W];
      end
   end

   if (PAD_W > 0) begin : g_pad
      assign rdata_o = {{PAD_W{1'b0}}, rd_field};
   end else begin : g_nopad
      assign rdata_o = rd_field;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_o <= 1'b0;
      else         err_o <= sel_i & ~acc_ok_i;
   end

   assign ctl_o = ctl_t'(flat_q);

   // R12: a refused write leaves every register untouched
   a_r12_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && wr_i && !acc_ok_i) |=> $stable(flat_q));
   // R12: a refused access reads zero and pulses the error output next cycle
   a_r12_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && !wr_i && !acc_ok_i) |-> (rdata_o == '0));
   a_r12_err_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && !acc_ok_i) |=> err_o);

endmodule

// File: rtl/tmr_pwr_gate.sv
module tmr_pwr_gate
   import tmr_pwr_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  pwr_mode_e mode_i,
   input  ctl_t      ctl_i,
   output logic      tmr_tick_o,
   output logic      acc_tick_o,
   output logic      acc_ok_o,
   output logic      pin_sel_o
)
;
   logic halted, wait_frozen, dbg_frozen;
   logic tmr_d, acc_d, ok_d, pin_d;

   always_comb begin
      halted      = (mode_i == MODE_STOP);
      wait_frozen = (mode_i == MODE_WAIT) && ctl_i.wait_frz;
      dbg_frozen  = (mode_i == MODE_DBG)  && ctl_i.dbg_frz;
      ok_d  = !halted && !wait_frozen;
      tmr_d = ctl_i.tmr_en && ok_d && !dbg_frozen;
      acc_d = ctl_i.acc_en && ok_d && !(dbg_frozen && !ctl_i.acc_evt);
      pin_d = ctl_i.acc_pin_en && !ctl_i.ch7_mode && !ctl_i.ch7_lvl && !ctl_i.ch7_mask;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tmr_tick_o <= 1'b0;
         acc_tick_o <= 1'b0;
         acc_ok_o   <= 1'b1;
         pin_sel_o  <= 1'b0;
      end else begin
         tmr_tick_o <= tmr_d;
         acc_tick_o <= acc_d;
         acc_ok_o   <= ok_d;
         pin_sel_o  <= pin_d;
      end
   end

   a_r4_dbg_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_DBG && ctl_i.dbg_frz) |=> !tmr_tick_o);
   a_r5_evt_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_DBG && ctl_i.acc_evt && ctl_i.acc_en) |=> acc_tick_o);
   a_r6_wait_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_WAIT && ctl_i.wait_frz) |=> (!tmr_tick_o && !acc_tick_o && !acc_ok_o));
   a_r9_stop_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_STOP) |=> (!tmr_tick_o && !acc_tick_o && !acc_ok_o));
   a_r11_pin_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i.ch7_mode || ctl_i.ch7_lvl || ctl_i.ch7_mask || !ctl_i.acc_pin_en) |=> !pin_sel_o);

endmodule

// File: rtl/tmr_pwr_ctl.sv
module tmr_pwr_ctl
   import tmr_pwr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cpu_stop_i,
   input  logic              cpu_wait_i,
   input  logic              cpu_dbg_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              bus_err_o,
   output logic              tmr_tick_en_o,
   output logic              acc_tick_en_o,
   output logic              reg_access_ok_o,
   output logic              ch7_to_acc_o
);

   pwr_mode_e mode;
   ctl_t      ctl;

   tmr_pwr_mode_dec u_dec (
      .stop_i (cpu_stop_i),
      .wait_i (cpu_wait_i),
      .dbg_i  (cpu_dbg_i),
      .mode_o (mode)
   );

   tmr_pwr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (bus_sel_i),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .acc_ok_i (reg_access_ok_o),
      .rdata_o  (bus_rdata_o),
      .err_o    (bus_err_o),
      .ctl_o    (ctl)
   );

   tmr_pwr_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode),
      .ctl_i      (ctl),
      .tmr_tick_o (tmr_tick_en_o),
      .acc_tick_o (acc_tick_en_o),
      .acc_ok_o   (reg_access_ok_o),
      .pin_sel_o  (ch7_to_acc_o)
   );

   // R10: stop overrides any simultaneous wait or debug request
   a_r10_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_stop_i && (cpu_wait_i || cpu_dbg_i)) |=> (!tmr_tick_en_o && !acc_tick_en_o));

endmodule

// File: tb/tmr_pwr_ctl_tb.sv
`timescale 1ns/1ps
module tmr_pwr_ctl_tb_top;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_r = 1'b0, wait_r = 1'b0, dbg_r = 1'b0;
   logic sel = 1'b0, wr = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic err, t_en, a_en, ok, pin;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tmr_pwr_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .cpu_stop_i(stop_r), .cpu_wait_i(wait_r), .cpu_dbg_i(dbg_r),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .bus_err_o(err),
      .tmr_tick_en_o(t_en), .acc_tick_en_o(a_en),
      .reg_access_ok_o(ok), .ch7_to_acc_o(pin)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic bus_write(input int a, input int d);
      sel = 1'b1; wr = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input int a, output int d);
      sel = 1'b1; wr = 1'b0; addr = ADDR_W'(a);
      #1 d = int'(rdata);
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic set_mode(input logic s, input logic w, input logic d);
      stop_r = s; wait_r = w; dbg_r = d;
   endtask

   task automatic t_reset();
      int d;
      check("R1 tmr tick", int'(t_en), 0);
      check("R1 acc tick", int'(a_en), 0);
      check("R1 pin sel", int'(pin), 0);
      check("R1 err", int'(err), 0);
      check("R1 access ok", int'(ok), 1);
      for (int i = 0; i < 3; i++) begin
         bus_read(i, d);
         check("R1 reg zero", d, 0);
      end
   endtask

   task automatic t_regmap();
      int d;
      bus_write(0, 8'hFA); bus_write(1, 8'h05); bus_write(2, 8'h03);
      bus_write(3, 8'h07); bus_write(15, 8'h07);
      bus_read(0, d); check("R14 SYS readback", d, 2);
      bus_read(1, d); check("R14 ACC readback", d, 5);
      bus_read(2, d); check("R14 CH7 readback", d, 3);
      bus_read(3, d); check("R14 unmapped 3", d, 0);
      bus_read(15, d); check("R14 unmapped 15", d, 0);
      bus_write(0, 0); bus_write(1, 0); bus_write(2, 0);
   endtask

   task automatic t_truth();
      for (int m = 0; m < 8; m++) begin
         for (int c = 0; c < 32; c++) begin
            logic s, w, g, te, df, wf, ae, ev, fw, fd, et, ea, eo;
            string tag;
            s = m[2]; w = m[1]; g = m[0];
            te = c[0]; df = c[1]; wf = c[2]; ae = c[3]; ev = c[4];
            set_mode(1'b0, 1'b0, 1'b0);
            @(negedge clk);
            bus_write(0, {wf, df, te});
            bus_write(1, {ev, 1'b0, ae});
            set_mode(s, w, g);
            @(negedge clk); @(negedge clk);
            fw = !s && w && wf;
            fd = !s && !w && g && df;
            eo = !s && !fw;
            et = te && eo && !fd;
            ea = ae && eo && !(fd && !ev);
            if ($countones({s, w, g}) > 1) tag = "R10 priority";
            else if (s) tag = "R9 stop";
            else if (w) tag = wf ? "R6 wait freeze" : "R7 wait run";
            else if (g) tag = !df ? "R3 debug no freeze" : (ev ? "R5 debug event" : "R4 debug freeze");
            else tag = "R2 run";
            check({tag, " tmr"}, int'(t_en), int'(et));
            check({tag, " acc"}, int'(a_en), int'(ea));
            check({tag, " ok"}, int'(ok), int'(eo));
         end
      end
      set_mode(1'b0, 1'b0, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_latency();
      bus_write(0, 1);
      @(negedge clk);
      check("R13 before stop", int'(t_en), 1);
      stop_r = 1'b1;
      #1 check("R13 held until edge", int'(t_en), 1);
      @(negedge clk);
      check("R13 off one edge later", int'(t_en), 0);
      check("R13 ok off one edge later", int'(ok), 0);
      stop_r = 1'b0;
      #1 check("R13 still off", int'(t_en), 0);
      @(negedge clk);
      check("R13 on one edge later", int'(t_en), 1);
      bus_write(0, 0);
   endtask

   task automatic t_wait_keep();
      int d;
      bus_write(0, 3'b101); bus_write(1, 3'b001);
      wait_r = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R8 frozen tmr", int'(t_en), 0);
      check("R8 frozen acc", int'(a_en), 0);
      bus_write(0, 0); bus_write(1, 0);
      wait_r = 1'b0;
      @(negedge clk); @(negedge clk);
      bus_read(0, d); check("R8 SYS kept", d, 5);
      bus_read(1, d); check("R8 ACC kept", d, 1);
      check("R8 tmr resumes", int'(t_en), 1);
      check("R8 acc resumes", int'(a_en), 1);
      bus_write(0, 0); bus_write(1, 0);
   endtask

   task automatic t_refused();
      int d;
      bus_write(2, 3'b101);
      bus_write(0, 3'b100);
      wait_r = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R12 err idle", int'(err), 0);
      bus_read(2, d);
      check("R12 read zero", d, 0);
      check("R12 err pulse", int'(err), 1);
      @(negedge clk);
      check("R12 err one cycle", int'(err), 0);
      bus_write(2, 3'b010);
      check("R12 err after write", int'(err), 1);
      wait_r = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R12 err cleared", int'(err), 0);
      bus_read(2, d);
      check("R12 write ignored", d, 5);
      check("R12 no err when allowed", int'(err), 0);
      bus_write(0, 0); bus_write(2, 0);
   endtask

   task automatic t_pin();
      for (int c = 0; c < 16; c++) begin
         logic pe, om, ol, mk;
         pe = c[0]; om = c[1]; ol = c[2]; mk = c[3];
         bus_write(1, {1'b0, pe, 1'b0});
         bus_write(2, {mk, ol, om});
         @(negedge clk);
         check("R11 pin select", int'(pin), int'(pe && !om && !ol && !mk));
      end
      bus_write(1, 0); bus_write(2, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_truth();
      t_latency();
      t_wait_keep();
      t_refused();
      t_pin();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule